// File: doc/BRIEF.md
# I2C Serial Memory Slave Engine

This block is the serial front end of a 256-byte, byte-addressed memory on a two-wire bus. It oversamples the clock and data lines with a fast system clock and spots bus START and STOP conditions. It answers one fixed 7-bit device address and then runs one of three transfers. A write loads a word address and hands each accepted data byte to a separate write-cycle unit. A read streams bytes out of the memory read port. A random read is a write-type address phase, then a repeated START, then a read-type device address.

An internal address counter always points one past the last byte accessed. Writes advance it only within a 16-byte page. Reads advance it across the full 8 bits. The engine drives the data line only through a pull-down enable. It withholds its acknowledge in three cases: while the write-cycle unit is busy (so the host can poll for completion), on data bytes while write protect is high, and while the supervisory reset is active.

Top module: `i2c_mem_slave`

## Requirements
- R1: START (data falls while clock high) begins a transfer and STOP (data rises while clock high) ends it; bytes sent before any START are never acknowledged.
- R2: The device byte is 7'b1010000 in bits 7..1 with R/W in bit 0 (1 = read, 0 = write), sent MSB first; on a match the slave pulls data low for the whole ninth clock, otherwise it leaves the line released and ignores the bus until the next START.
- R3: In a write, the byte after the device byte loads the address counter; every later data byte is acknowledged and handed off as one single-cycle `wr_valid_o` pulse carrying the target address and the data.
- R4: Successive write data bytes advance only address bits 3..0, so a page write wraps inside its 16-byte page and leaves bits 7..4 unchanged.
- R5: A STOP that ends a write with at least one accepted data byte pulses `wr_commit_o` for one cycle; a STOP that ends any other transfer does not.
- R6: While `busy_i` is high, the slave does not acknowledge its own device byte, in either direction.
- R7: While `wp_i` is high, the device byte and the word address are acknowledged, but data bytes are not; nothing is handed off and no commit follows.
- R8: In a read, the slave sends 8 bits MSB first, then releases the line; a master acknowledge makes it send the next byte, and a master no-acknowledge makes it stay released until the next START or STOP.
- R9: The address counter holds the last accessed address plus one; a read with no preceding address phase starts there, and reads advance the counter across all 8 bits, wrapping from 255 to 0.
- R10: A random read (write-type device byte, word address, repeated START, read-type device byte) returns the byte at the given word address.
- R11: While `reset_act_i` is high, any transfer is aborted, the data line is released, no device byte is acknowledged, and data accepted before the abort is never committed.
- R12: `sda_pd_o` changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pd_o | output | 1 | Pull the data line low |
| rd_addr_o | output | 8 | Memory read address (address counter) |
| rd_data_i | input | 8 | Memory read data for `rd_addr_o`, combinational |
| wr_valid_o | output | 1 | One accepted write byte is handed off |
| wr_addr_o | output | 8 | Address of the handed-off byte |
| wr_data_o | output | 8 | Data of the handed-off byte |
| wr_commit_o | output | 1 | Start the internal write cycle for the handed-off bytes |
| busy_i | input | 1 | Internal write cycle in progress |
| wp_i | input | 1 | Write protect |
| reset_act_i | input | 1 | Supervisory reset active |

## Verification
Two actions can land in the same cycle. The supervisory reset can arrive while a write is open and bytes have already been handed off, so the abort competes with the pending commit at the next STOP. The busy flag can still be high when a polling device byte reaches its acknowledge decision, so the address match competes with the busy refusal. The bench provokes the first case by raising the reset right after an accepted data byte and then issuing a STOP. It expects no further acknowledge, no commit, and memory contents left untouched. It provokes the second case by polling right after a write's STOP. It expects a no-acknowledge while the modelled write cycle is still running, and an acknowledge once the cycle is over.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA,
    ST_WAIT
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int NL = 2;
  logic [NL-1:0] raw;
  logic [NL-1:0] cur, prv;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NL; g++) begin : g_line
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff     <= '1;
        prv[g] <= 1'b1;
      end else begin
        ff     <= {ff[STAGES-2:0], raw[g]};
        prv[g] <= ff[STAGES-1];
      end
    end
    assign cur[g] = ff[STAGES-1];
  end

  assign scl_o      = cur[0];
  assign sda_o      = cur[1];
  assign scl_rise_o = cur[0] & ~prv[0];
  assign scl_fall_o = ~cur[0] & prv[0];
  assign start_o    = cur[0] & prv[0] & prv[1] & ~cur[1];
  assign stop_o     = cur[0] & prv[0] & ~prv[1] & cur[1];
endmodule

// File: rtl/i2c_addr_ctr.sv
module i2c_addr_ctr #(
  parameter int AW = 8,
  parameter int PAGE_BITS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_rd_i,
  input  logic          inc_wr_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;
  logic [PAGE_BITS-1:0] low_inc;

  assign low_inc = addr_q[PAGE_BITS-1:0] + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (load_i)   addr_q <= load_val_i;
    else if (inc_rd_i) addr_q <= addr_q + 1'b1;
    else if (inc_wr_i) addr_q <= {addr_q[AW-1:PAGE_BITS], low_inc};
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter int         AW          = 8,
  parameter int         PAGE_BITS   = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h50
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pd_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          wr_commit_o,
  input  logic          busy_i,
  input  logic          wp_i,
  input  logic          reset_act_i
);
  localparam int CW = 4;
  localparam logic [CW-1:0] BITS_PER_BYTE = CW'(8);

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  slv_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0]    sh_q, sh_d, tx_q, tx_d;
  logic          ack_q, ack_d, pd_q, pd_d, rd_q, rd_d;
  logic          mack_q, mack_d, wrote_q, wrote_d;
  logic          ctr_load, ctr_inc_rd, ctr_inc_wr, wv, cm;
  logic          wv_q, cm_q;
  logic [AW-1:0] addr, wa_q;
  logic [7:0]    wd_q;
  logic          dev_hit;

  i2c_addr_ctr #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ctr_load),
    .load_val_i (AW'(sh_q)),
    .inc_rd_i   (ctr_inc_rd),
    .inc_wr_i   (ctr_inc_wr),
    .addr_o     (addr)
  );

  assign dev_hit = (sh_q[7:1] == DEV_ADDR) && !busy_i;

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    tx_d       = tx_q;
    ack_d      = ack_q;
    pd_d       = pd_q;
    rd_d       = rd_q;
    mack_d     = mack_q;
    wrote_d    = wrote_q;
    ctr_load   = 1'b0;
    ctr_inc_rd = 1'b0;
    ctr_inc_wr = 1'b0;
    wv         = 1'b0;
    cm         = 1'b0;
    if (reset_act_i) begin
      st_d    = ST_IDLE;
      pd_d    = 1'b0;
      ack_d   = 1'b0;
      wrote_d = 1'b0;
    end else if (bus_start) begin
      st_d  = ST_DEV;
      cnt_d = '0;
      ack_d = 1'b0;
      pd_d  = 1'b0;
    end else if (bus_stop) begin
      cm      = wrote_q;
      wrote_d = 1'b0;
      st_d    = ST_IDLE;
      pd_d    = 1'b0;
      ack_d   = 1'b0;
    end else begin
      unique case (st_q)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise && !ack_q && cnt_q != BITS_PER_BYTE) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && !ack_q && cnt_q == BITS_PER_BYTE) begin
            ack_d = 1'b1;
            if (st_q == ST_DEV) begin
              pd_d = dev_hit;
              rd_d = sh_q[0];
            end else if (st_q == ST_WADDR) begin
              pd_d     = 1'b1;
              ctr_load = 1'b1;
            end else begin
              pd_d = !wp_i;
              if (!wp_i) begin
                wv         = 1'b1;
                ctr_inc_wr = 1'b1;
                wrote_d    = 1'b1;
              end
            end
          end else if (scl_fall && ack_q) begin
            ack_d = 1'b0;
            cnt_d = '0;
            pd_d  = 1'b0;
            if (!pd_q) begin
              st_d = ST_WAIT;
            end else if (st_q == ST_DEV && rd_q) begin
              st_d       = ST_RDATA;
              tx_d       = rd_data_i;
              pd_d       = !rd_data_i[7];
              ctr_inc_rd = 1'b1;
            end else if (st_q == ST_DEV) begin
              st_d = ST_WADDR;
            end else begin
              st_d = ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (!ack_q) begin
            if (scl_rise) begin
              cnt_d = cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == BITS_PER_BYTE) begin
                ack_d = 1'b1;
                pd_d  = 1'b0;
              end else begin
                pd_d = !tx_q[3'd7 - cnt_q[2:0]];
              end
            end
          end else begin
            if (scl_rise) begin
              mack_d = !sda_s;
            end else if (scl_fall) begin
              ack_d = 1'b0;
              cnt_d = '0;
              if (mack_q) begin
                tx_d       = rd_data_i;
                pd_d       = !rd_data_i[7];
                ctr_inc_rd = 1'b1;
              end else begin
                st_d = ST_WAIT;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      ack_q   <= 1'b0;
      pd_q    <= 1'b0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
      wrote_q <= 1'b0;
      wv_q    <= 1'b0;
      cm_q    <= 1'b0;
      wa_q    <= '0;
      wd_q    <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      ack_q   <= ack_d;
      pd_q    <= pd_d;
      rd_q    <= rd_d;
      mack_q  <= mack_d;
      wrote_q <= wrote_d;
      wv_q    <= wv;
      cm_q    <= cm;
      if (wv) begin
        wa_q <= addr;
        wd_q <= sh_q;
      end
    end
  end

  assign sda_pd_o    = pd_q;
  assign rd_addr_o   = addr;
  assign wr_valid_o  = wv_q;
  assign wr_addr_o   = wa_q;
  assign wr_data_o   = wd_q;
  assign wr_commit_o = cm_q;
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_pd_o,
  input logic wr_valid_o,
  input logic wr_commit_o,
  input logic busy_i,
  input logic wp_i,
  input logic reset_act_i
);
  AST_PD_CHANGE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pd_o) |-> !scl_i); // R12
  AST_WR_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o); // R3
  AST_COMMIT_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |=> !wr_commit_o); // R5
  AST_NO_WR_UNDER_WP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i && $past(wp_i) |-> !wr_valid_o); // R7
  AST_RESET_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_act_i |=> !sda_pd_o && !wr_commit_o && !wr_valid_o); // R11
  AST_NO_WR_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) |-> !wr_valid_o); // R6
endmodule

bind i2c_mem_slave i2c_mem_slave_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_i       (scl_i),
  .sda_pd_o    (sda_pd_o),
  .wr_valid_o  (wr_valid_o),
  .wr_commit_o (wr_commit_o),
  .busy_i      (busy_i),
  .wp_i        (wp_i),
  .reset_act_i (reset_act_i)
);

// File: tb/i2c_mem_slave_tb.sv
module i2c_mem_slave_tb;
  localparam int Q = 8;
  localparam int BUSY_CYC = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic wp = 1'b0, rst_act = 1'b0;
  logic sda_pd, wr_valid, wr_commit, busy;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
  logic bus;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [15:0] exp_wr [$];
  logic [15:0] pend [$];
  int busy_cnt = 0;
  int commits = 0;
  int exp_commits = 0;
  int n_cmp = 0, n_bad = 0;
  int exp_ptr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign bus     = sda_m & ~sda_pd;
  assign rd_data = mem[rd_addr];
  assign busy    = (busy_cnt != 0);

  i2c_mem_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(bus), .sda_pd_o(sda_pd),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .wr_valid_o(wr_valid),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_commit_o(wr_commit),
    .busy_i(busy), .wp_i(wp), .reset_act_i(rst_act)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write-cycle unit model and per-clock handoff comparison
  initial for (int i = 0; i < 256; i++) begin
    mem[i] = 8'(i) ^ 8'hA5;
    exp_mem[i] = 8'(i) ^ 8'hA5;
  end

  always @(negedge clk) begin
    if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if (rst_act) pend.delete();
    if (wr_valid) begin
      if (exp_wr.size() == 0) chk(0, "R3/R7 unexpected handoff", {wr_addr, wr_data}, 0);
      else begin
        logic [15:0] e;
        e = exp_wr.pop_front();
        chk({wr_addr, wr_data} == e, "R3/R4 handoff", {wr_addr, wr_data}, e);
      end
      pend.push_back({wr_addr, wr_data});
    end
    if (wr_commit) begin
      commits++;
      foreach (pend[k]) mem[pend[k][15:8]] = pend[k][7:0];
      pend.delete();
      busy_cnt <= BUSY_CYC;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b, output logic r);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q);
    r = bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic r;
    for (int i = 7; i >= 0; i--) put_bit(b[i], r);
    put_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      put_bit(1'b1, r);
      d[i] = r;
    end
    put_bit(!mack, r);
  endtask

  task automatic exp_ack(input logic [7:0] b, input bit e, input string req);
    bit a;
    send_byte(b, a);
    chk(a == e, req, a, e);
  endtask

  // sequential read of n bytes after the device byte, checked against exp_mem
  task automatic read_n(input int n, input string req);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk(d == exp_mem[exp_ptr], req, d, exp_mem[exp_ptr]);
      exp_ptr = (exp_ptr + 1) % 256;
    end
    tick(Q);
    chk(sda_pd == 1'b0, "R8 released after master nack", sda_pd, 0);
  endtask

  task automatic rand_read(input logic [7:0] a, input int n, input string req);
    bus_start();
    exp_ack(8'hA0, 1, "R2 write device byte");
    exp_ack(a, 1, "R10 word address");
    bus_start();
    exp_ack(8'hA1, 1, "R10 read device byte after repeated START");
    exp_ptr = a;
    read_n(n, req);
    bus_stop();
  endtask

  task automatic page_write(input logic [7:0] a, input logic [7:0] d [$]);
    logic [7:0] p;
    p = a;
    bus_start();
    exp_ack(8'hA0, 1, "R2 write device byte");
    exp_ack(a, 1, "R3 word address");
    foreach (d[i]) begin
      exp_wr.push_back({p, d[i]});
      exp_mem[p] = d[i];
      exp_ack(d[i], 1, "R3 data byte");
      p = {p[7:4], p[3:0] + 4'd1};
    end
    exp_ptr = p;
    bus_stop();
    tick(4);
    exp_commits++;
    chk(commits == exp_commits, "R5 commit after write STOP", commits, exp_commits);
  endtask

  initial begin
    int wd;
    logic [7:0] d;
    bit a;
    wd = 0;
    fork
      begin
        while (!done && wd < 150000) begin tick(1); wd++; end
        if (!done) begin
          chk(0, "watchdog", wd, 0);
          $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
          $finish;
        end
      end
    join_none

    tick(5);
    chk(sda_pd == 0 && wr_valid == 0 && wr_commit == 0, "R1 reset state", {sda_pd, wr_valid, wr_commit}, 0);
    rst_n = 1'b1;
    tick(5);

    // R1: no START yet
    exp_ack(8'hA0, 0, "R1 byte before any START");

    // R2: wrong device address
    bus_start();
    exp_ack(8'hA2, 0, "R2 non-matching device byte");
    exp_ack(8'hA0, 0, "R2 ignored until next START");
    bus_stop();

    // R3/R5 byte write then R6 polling
    page_write(8'h10, '{8'h3C});
    bus_start();
    exp_ack(8'hA0, 0, "R6 poll while busy");
    bus_stop();
    tick(BUSY_CYC + 50);
    bus_start();
    exp_ack(8'hA0, 1, "R6 poll after write cycle");
    bus_stop();
    tick(4);
    chk(commits == exp_commits, "R5 no commit for address-only write", commits, exp_commits);

    // R10 random read, R9 current read
    rand_read(8'h10, 1, "R10 random read data");
    bus_start();
    exp_ack(8'hA1, 1, "R9 current read device byte");
    read_n(1, "R9 current address read");
    bus_stop();

    // R8/R9 sequential read wrapping 255 -> 0
    rand_read(8'hFE, 3, "R9 sequential read wrap");
    bus_start();
    exp_ack(8'hA1, 1, "R9 current read device byte");
    read_n(1, "R9 counter after wrap");
    bus_stop();

    // R4 page write wrapping inside page
    page_write(8'h0E, '{8'h11, 8'h22, 8'h33, 8'h44});
    tick(BUSY_CYC + 50);
    rand_read(8'h0E, 2, "R4 page head");
    rand_read(8'h00, 3, "R4 page wrapped bytes");

    // R7 write protect
    wp = 1'b1;
    bus_start();
    exp_ack(8'hA0, 1, "R7 device byte under protect");
    exp_ack(8'h20, 1, "R7 word address under protect");
    exp_ack(8'h99, 0, "R7 first data byte refused");
    bus_stop();
    tick(4);
    chk(commits == exp_commits, "R7 no commit under protect", commits, exp_commits);
    wp = 1'b0;
    rand_read(8'h20, 1, "R7 memory unchanged");

    // R11 abort mid-write, then refusal while reset active
    bus_start();
    exp_ack(8'hA0, 1, "R2 write device byte");
    exp_ack(8'h40, 1, "R3 word address");
    exp_wr.push_back({8'h40, 8'h77});
    exp_ack(8'h77, 1, "R3 data byte before abort");
    rst_act = 1'b1;
    tick(5);
    chk(sda_pd == 0, "R11 line released", sda_pd, 0);
    rst_act = 1'b0;
    exp_ack(8'h78, 0, "R11 aborted transfer");
    bus_stop();
    tick(4);
    chk(commits == exp_commits, "R11 no commit after abort", commits, exp_commits);
    rst_act = 1'b1;
    bus_start();
    exp_ack(8'hA1, 0, "R11 device byte during reset");
    bus_stop();
    rst_act = 1'b0;
    rand_read(8'h40, 1, "R11 memory unchanged");

    tick(20);
    chk(exp_wr.size() == 0, "R3 all expected handoffs seen", exp_wr.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule